// File: doc/BRIEF.md
# Fine-Grained Label Egress Port Selector

This block sits at the egress side of a switch that carries packets tagged with a 24-bit fine-grained label. When a packet has been decapsulated, the block decides which local output ports get a copy and what customer VLAN tag each copy carries. Each port keeps a small table of the labels it serves. Each entry of that table also gives the C-VLAN ID to use on that port for that label. Two ports may therefore map the same label to different C-VLANs.

A request carries the full label and the user priority and DEI taken from the label's low part. It also carries the forwarding class of the packet: multi-destination, broadcast/multicast inner destination, or unicast. For unicast there is a known-port hint from an external MAC lookup, plus an unreachable-port mask. A multicast pruning mask is supplied too. There is also a flag for the all-egress-switches destination and a flag saying whether the payload Ethertype is known. The result appears a fixed two cycles after the request strobe. An empty port mask with no special-processing flag means the packet is dropped.

The tables are written one entry at a time through a configuration write port. A per-port strip-tag setting tells which ports send frames out untagged.

Top module: `fgl_egress_sel`

## Requirements
- R1: `vld_o` pulses exactly two clock cycles after each cycle in which `req_i` is high, and never otherwise. All outputs are zero after reset.
- R2: A port is a member for a request only if one of its valid entries holds a label equal to all 24 bits of `label_i`. An entry with the same upper 12 bits but a different lower 12 bits never makes the port a member.
- R3: Known unicast is the case `mdest_i`=0, `bcmc_i`=0, `known_vld_i`=1. For it, `port_mask_o` equals the member ports ANDed with `known_mask_i`.
- R4: Unknown unicast is the case `mdest_i`=0, `bcmc_i`=0, `known_vld_i`=0. For it, `port_mask_o` equals the member ports with the ports in `unreach_mask_i` removed.
- R5: When `mdest_i`=1 or `bcmc_i`=1, `port_mask_o` equals the member ports with the ports in `prune_mask_i` removed. `known_mask_i` has no effect in this case.
- R6: When `all_egress_i`=1, `port_mask_o` is zero and `special_o` equals `etype_known_i`. `special_o` is zero for every other request.
- R7: Port p's C-VLAN ID is placed in `vid_o[p*12 +: 12]`. It comes from that port's matching entry; when several valid entries of one port hold the same label, the lowest entry index wins. The field is zero for ports not in `port_mask_o`.
- R8: `pcp_o` and `dei_o` repeat the `pcp_i` and `dei_i` of the request, which carry the low-part priority.
- R9: `strip_o[p]` equals `strip_cfg_i[p]` for ports in `port_mask_o` and is zero elsewhere.
- R10: A configuration write is applied at the clock edge where `cfg_we_i` is sampled high. It sets entry `cfg_idx_i` of port `cfg_port_i` to the values on `cfg_valid_i`, `cfg_label_i` and `cfg_vid_i`. Writing `cfg_valid_i`=0 removes the entry from matching.
- R11: A request that matches no eligible port gives `vld_o`=1 with `port_mask_o`=0 and `special_o`=0, which means drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table entry write strobe |
| cfg_port_i | input | 2 | Port whose table is written |
| cfg_idx_i | input | 3 | Entry index within the port table |
| cfg_valid_i | input | 1 | Valid bit of the written entry |
| cfg_label_i | input | 24 | Label of the written entry |
| cfg_vid_i | input | 12 | C-VLAN ID of the written entry |
| strip_cfg_i | input | 4 | Per-port strip-tag setting |
| req_i | input | 1 | Request strobe |
| label_i | input | 24 | Packet label, high part in bits 23:12 |
| pcp_i | input | 3 | Priority from the label low part |
| dei_i | input | 1 | DEI from the label low part |
| mdest_i | input | 1 | Packet is multi-destination |
| bcmc_i | input | 1 | Inner destination MAC is broadcast or multicast |
| all_egress_i | input | 1 | Inner destination is the all-egress-switches address |
| etype_known_i | input | 1 | Payload Ethertype has a special handler |
| known_vld_i | input | 1 | External MAC lookup found the destination |
| known_mask_i | input | 4 | Ports given by the MAC lookup |
| unreach_mask_i | input | 4 | Ports known not to reach the destination |
| prune_mask_i | input | 4 | Multicast pruning mask |
| vld_o | output | 1 | Result valid |
| port_mask_o | output | 4 | Selected output ports |
| special_o | output | 1 | Hand packet to special processing |
| vid_o | output | 48 | Per-port C-VLAN ID, 12 bits per port |
| pcp_o | output | 3 | Restored priority |
| dei_o | output | 1 | Restored DEI |
| strip_o | output | 4 | Per-port strip-tag flag |

## Verification
The same label is sent in each of the three forwarding classes. Known unicast, unknown unicast and flooded multi-destination traffic give different masks only if the block uses the right one of the hint, unreachable and prune masks. A label that differs from a configured one only in its low part shows whether the whole 24 bits are compared. A duplicate label placed at two indices of one port shows whether the lowest index wins. The all-egress cases are run with both Ethertype settings to tell special hand-off apart from discard. An entry is removed and written back to show that table writes take effect at once.

// File: rtl/fgl_egr_pkg.sv
package fgl_egr_pkg;
  localparam int LABEL_W = 24;
  localparam int CVID_W  = 12;
  localparam int PCP_W   = 3;

  typedef struct packed {
    logic [LABEL_W-1:0] label;
    logic [PCP_W-1:0]   pcp;
    logic               dei;
    logic               mdest;
    logic               bcmc;
    logic               all_egress;
    logic               etype_known;
    logic               known_vld;
  } req_t;
endpackage

// File: rtl/fgl_port_table.sv
module fgl_port_table
  import fgl_egr_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_valid_i,
  input  logic [LABEL_W-1:0] wr_label_i,
  input  logic [CVID_W-1:0]  wr_vid_i,
  input  logic [LABEL_W-1:0] lookup_label_i,
  output logic               hit_o,
  output logic [CVID_W-1:0]  vid_o
);
  logic [ENTRIES-1:0] vld_q;
  logic [LABEL_W-1:0] lbl_q [ENTRIES];
  logic [CVID_W-1:0]  vid_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e] <= 1'b0;
        lbl_q[e] <= '0;
        vid_q[e] <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(e)) begin
        vld_q[e] <= wr_valid_i;
        lbl_q[e] <= wr_label_i;
        vid_q[e] <= wr_vid_i;
      end
    end
    // full-width compare, both label halves
    assign match[e] = vld_q[e] && (lbl_q[e] == lookup_label_i);
  end

  // lowest index wins on duplicates
  always_comb begin
    hit_o = 1'b0;
    vid_o = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match[e]) begin
        hit_o = 1'b1;
        vid_o = vid_q[e];
      end
    end
  end

  // R10
  wr_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vld_q[$past(wr_idx_i)] == $past(wr_valid_i));

  // R2
  hit_needs_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (vld_q != '0));
endmodule

// File: rtl/fgl_dest_select.sv
module fgl_dest_select #(
  parameter int NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0] member_i,
  input  logic                 mdest_i,
  input  logic                 bcmc_i,
  input  logic                 all_egress_i,
  input  logic                 etype_known_i,
  input  logic                 known_vld_i,
  input  logic [NUM_PORTS-1:0] known_mask_i,
  input  logic [NUM_PORTS-1:0] unreach_mask_i,
  input  logic [NUM_PORTS-1:0] prune_mask_i,
  output logic [NUM_PORTS-1:0] mask_o,
  output logic                 special_o
);
  always_comb begin
    special_o = 1'b0;
    if (all_egress_i) begin
      mask_o    = '0;
      special_o = etype_known_i;
    end else if (mdest_i || bcmc_i) begin
      mask_o = member_i & ~prune_mask_i;
    end else if (known_vld_i) begin
      mask_o = member_i & known_mask_i;
    end else begin
      mask_o = member_i & ~unreach_mask_i;
    end
  end
endmodule

// File: rtl/fgl_egress_sel.sv
module fgl_egress_sel
  import fgl_egr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ENTRIES   = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_we_i,
  input  logic [PORT_W-1:0]           cfg_port_i,
  input  logic [IDX_W-1:0]            cfg_idx_i,
  input  logic                        cfg_valid_i,
  input  logic [LABEL_W-1:0]          cfg_label_i,
  input  logic [CVID_W-1:0]           cfg_vid_i,
  input  logic [NUM_PORTS-1:0]        strip_cfg_i,
  input  logic                        req_i,
  input  logic [LABEL_W-1:0]          label_i,
  input  logic [PCP_W-1:0]            pcp_i,
  input  logic                        dei_i,
  input  logic                        mdest_i,
  input  logic                        bcmc_i,
  input  logic                        all_egress_i,
  input  logic                        etype_known_i,
  input  logic                        known_vld_i,
  input  logic [NUM_PORTS-1:0]        known_mask_i,
  input  logic [NUM_PORTS-1:0]        unreach_mask_i,
  input  logic [NUM_PORTS-1:0]        prune_mask_i,
  output logic                        vld_o,
  output logic [NUM_PORTS-1:0]        port_mask_o,
  output logic                        special_o,
  output logic [NUM_PORTS*CVID_W-1:0] vid_o,
  output logic [PCP_W-1:0]            pcp_o,
  output logic                        dei_o,
  output logic [NUM_PORTS-1:0]        strip_o
);
  // stage 1: capture request
  logic                 s1_vld;
  req_t                 s1_req;
  logic [NUM_PORTS-1:0] s1_known, s1_unreach, s1_prune;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld     <= 1'b0;
      s1_req     <= '0;
      s1_known   <= '0;
      s1_unreach <= '0;
      s1_prune   <= '0;
    end else begin
      s1_vld <= req_i;
      if (req_i) begin
        s1_req     <= '{label: label_i, pcp: pcp_i, dei: dei_i, mdest: mdest_i,
                        bcmc: bcmc_i, all_egress: all_egress_i,
                        etype_known: etype_known_i, known_vld: known_vld_i};
        s1_known   <= known_mask_i;
        s1_unreach <= unreach_mask_i;
        s1_prune   <= prune_mask_i;
      end
    end
  end

  // stage 2: parallel lookup across all port tables
  logic [NUM_PORTS-1:0]        member;
  logic [NUM_PORTS*CVID_W-1:0] port_vid;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    fgl_port_table #(.ENTRIES(ENTRIES)) u_tbl (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wr_en_i        (cfg_we_i && cfg_port_i == PORT_W'(p)),
      .wr_idx_i       (cfg_idx_i),
      .wr_valid_i     (cfg_valid_i),
      .wr_label_i     (cfg_label_i),
      .wr_vid_i       (cfg_vid_i),
      .lookup_label_i (s1_req.label),
      .hit_o          (member[p]),
      .vid_o          (port_vid[p*CVID_W +: CVID_W])
    );
  end

  logic [NUM_PORTS-1:0] sel_mask;
  logic                 sel_special;

  fgl_dest_select #(.NUM_PORTS(NUM_PORTS)) u_sel (
    .member_i       (member),
    .mdest_i        (s1_req.mdest),
    .bcmc_i         (s1_req.bcmc),
    .all_egress_i   (s1_req.all_egress),
    .etype_known_i  (s1_req.etype_known),
    .known_vld_i    (s1_req.known_vld),
    .known_mask_i   (s1_known),
    .unreach_mask_i (s1_unreach),
    .prune_mask_i   (s1_prune),
    .mask_o         (sel_mask),
    .special_o      (sel_special)
  );

  logic [NUM_PORTS*CVID_W-1:0] vid_gated;
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_gate
    assign vid_gated[p*CVID_W +: CVID_W] =
      sel_mask[p] ? port_vid[p*CVID_W +: CVID_W] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o       <= 1'b0;
      port_mask_o <= '0;
      special_o   <= 1'b0;
      vid_o       <= '0;
      pcp_o       <= '0;
      dei_o       <= 1'b0;
      strip_o     <= '0;
    end else begin
      vld_o <= s1_vld;
      if (s1_vld) begin
        port_mask_o <= sel_mask;
        special_o   <= sel_special;
        vid_o       <= vid_gated;
        pcp_o       <= s1_req.pcp;
        dei_o       <= s1_req.dei;
        strip_o     <= strip_cfg_i & sel_mask;
      end
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == $past(req_i, 2));

  // R6
  all_egress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && $past(all_egress_i, 2)) |-> (port_mask_o == '0));

  // R6
  special_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && special_o) |-> (port_mask_o == '0));

  // R5
  prune_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && $past(mdest_i, 2) && !$past(all_egress_i, 2))
      |-> ((port_mask_o & $past(prune_mask_i, 2)) == '0));

  // R3
  known_uc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && $past(known_vld_i && !mdest_i && !bcmc_i, 2))
      |-> ((port_mask_o & ~$past(known_mask_i, 2)) == '0));

  // R8
  pcp_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (pcp_o == $past(pcp_i, 2) && dei_o == $past(dei_i, 2)));

  // R9
  strip_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> ((strip_o & ~port_mask_o) == '0));
endmodule

// File: tb/fgl_egress_sel_tb.sv
module fgl_egress_sel_tb_top;
  localparam int P = 4;
  localparam int E = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic          cfg_we_i = 0;
  logic [1:0]    cfg_port_i = 0;
  logic [2:0]    cfg_idx_i = 0;
  logic          cfg_valid_i = 0;
  logic [23:0]   cfg_label_i = 0;
  logic [11:0]   cfg_vid_i = 0;
  logic [P-1:0]  strip_cfg_i = 4'b1010;
  logic          req_i = 0;
  logic [23:0]   label_i = 0;
  logic [2:0]    pcp_i = 0;
  logic          dei_i = 0, mdest_i = 0, bcmc_i = 0, all_egress_i = 0;
  logic          etype_known_i = 0, known_vld_i = 0;
  logic [P-1:0]  known_mask_i = 0, unreach_mask_i = 0, prune_mask_i = 0;
  logic          vld_o, special_o, dei_o;
  logic [P-1:0]  port_mask_o, strip_o;
  logic [P*12-1:0] vid_o;
  logic [2:0]    pcp_o;

  fgl_egress_sel #(.NUM_PORTS(P), .ENTRIES(E)) dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the tables
  logic        m_v   [P][E];
  logic [23:0] m_lbl [P][E];
  logic [11:0] m_vid [P][E];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int p, input int idx, input logic v,
                           input logic [23:0] lbl, input logic [11:0] vid);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_port_i = 2'(p); cfg_idx_i = 3'(idx);
    cfg_valid_i = v; cfg_label_i = lbl; cfg_vid_i = vid;
    m_v[p][idx] = v; m_lbl[p][idx] = lbl; m_vid[p][idx] = vid;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic run_req(input string tag, input logic [23:0] lbl, input logic [2:0] pcp,
                         input logic dei, input logic md, input logic bm, input logic ae,
                         input logic ek, input logic kv, input logic [P-1:0] km,
                         input logic [P-1:0] um, input logic [P-1:0] pm);
    logic [P-1:0]    mem, emask;
    logic [P*12-1:0] evid;
    logic [11:0]     pv [P];
    for (int p = 0; p < P; p++) begin
      mem[p] = 0; pv[p] = 0;
      for (int i = 0; i < E; i++)
        if (!mem[p] && m_v[p][i] && m_lbl[p][i] == lbl) begin
          mem[p] = 1; pv[p] = m_vid[p][i];
        end
    end
    if (ae) emask = '0;
    else if (md || bm) emask = mem & ~pm;
    else if (kv) emask = mem & km;
    else emask = mem & ~um;
    evid = '0;
    for (int p = 0; p < P; p++) if (emask[p]) evid[p*12 +: 12] = pv[p];

    @(negedge clk_i);
    req_i = 1; label_i = lbl; pcp_i = pcp; dei_i = dei; mdest_i = md; bcmc_i = bm;
    all_egress_i = ae; etype_known_i = ek; known_vld_i = kv;
    known_mask_i = km; unreach_mask_i = um; prune_mask_i = pm;
    @(negedge clk_i);
    req_i = 0;
    chk({tag, " R1 vld early"}, 64'(vld_o), 64'd0);
    @(negedge clk_i);
    chk({tag, " R1 vld"}, 64'(vld_o), 64'd1);
    chk({tag, " mask"}, 64'(port_mask_o), 64'(emask));
    chk({tag, " R6 special"}, 64'(special_o), 64'(ae & ek));
    chk({tag, " R7 vid"}, 64'(vid_o), 64'(evid));
    chk({tag, " R8 pcp/dei"}, 64'({pcp_o, dei_o}), 64'({pcp, dei}));
    chk({tag, " R9 strip"}, 64'(strip_o), 64'(strip_cfg_i & emask));
    @(negedge clk_i);
    chk({tag, " R1 single pulse"}, 64'(vld_o), 64'd0);
  endtask

  localparam logic [23:0] LA = 24'h123_456;
  localparam logic [23:0] LB = 24'h9AB_001;
  localparam logic [23:0] LC = 24'h123_457;

  task automatic t_reset();
    chk("R1 reset vld", 64'(vld_o), 0);
    chk("R1 reset mask", 64'(port_mask_o), 0);
    chk("R1 reset vid", 64'(vid_o), 0);
    chk("R1 reset misc", 64'({special_o, pcp_o, dei_o, strip_o}), 0);
  endtask

  task automatic t_setup();
    for (int p = 0; p < P; p++)
      for (int i = 0; i < E; i++) begin
        m_v[p][i] = 0; m_lbl[p][i] = 0; m_vid[p][i] = 0;
      end
    cfg_write(0, 0, 1, LA, 12'h010);
    cfg_write(1, 2, 1, LA, 12'h020);
    cfg_write(1, 5, 1, LB, 12'h021);
    cfg_write(2, 0, 1, LC, 12'h030);  // same high part as LA
    cfg_write(2, 7, 1, LB, 12'h031);
    cfg_write(3, 4, 1, LA, 12'h041);
    cfg_write(3, 1, 1, LA, 12'h040);  // duplicate, lower index
  endtask

  task automatic t_known_uc();  // R3, R2, R7
    run_req("R3 known uc", LA, 3'd5, 1, 0, 0, 0, 0, 1, 4'b0011, 4'b0000, 4'b0000);
    run_req("R3 known uc hint", LA, 3'd1, 0, 0, 0, 0, 0, 1, 4'b1100, 4'b1111, 4'b1111);
  endtask

  task automatic t_unknown_uc();  // R4
    run_req("R4 unknown uc", LA, 3'd2, 0, 0, 0, 0, 0, 0, 4'b1111, 4'b1000, 4'b1111);
  endtask

  task automatic t_flood();  // R5, R7 lowest index on port 3
    run_req("R5 mdest prune", LA, 3'd7, 1, 1, 0, 0, 0, 1, 4'b0001, 4'b1111, 4'b0010);
    run_req("R5 bcmc", LB, 3'd3, 0, 0, 1, 0, 0, 1, 4'b0000, 4'b1111, 4'b0000);
    run_req("R5 R7 dup lowest idx", LA, 3'd0, 0, 1, 0, 0, 0, 0, 4'b0000, 4'b0000, 4'b0000);
  endtask

  task automatic t_exact();  // R2, R11
    run_req("R2 R11 low part differs", 24'h123_458, 3'd4, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    run_req("R2 exact LC only", LC, 3'd6, 0, 1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_all_egress();  // R6
    run_req("R6 special known", LA, 3'd5, 0, 1, 0, 1, 1, 1, 4'b1111, 0, 0);
    run_req("R6 discard", LA, 3'd5, 1, 0, 0, 1, 0, 1, 4'b1111, 0, 0);
  endtask

  task automatic t_cfg();  // R10
    cfg_write(0, 0, 0, LA, 12'h010);
    run_req("R10 removed", LA, 3'd2, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    cfg_write(0, 6, 1, LA, 12'h0FF);
    run_req("R10 rewritten", LA, 3'd2, 0, 1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_strip();  // R9
    strip_cfg_i = 4'b0111;
    run_req("R9 strip cfg", LA, 3'd1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    strip_cfg_i = 4'b1010;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    t_setup();
    t_known_uc();
    t_unknown_uc();
    t_flood();
    t_exact();
    t_all_egress();
    t_cfg();
    t_strip();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule